// File: doc/BRIEF.md
# Address-Wake Serial Receiver

This block receives asynchronous serial frames that carry a ninth bit after the eight data bits. That bit tells the receiver which kind of frame it is. When the bit is 1 the frame is an ID (address) frame. When it is 0 the frame carries data. Several receivers can share one line this way. Each one ignores the data traffic until an ID frame arrives, and its software then checks whether the ID is its own.

A register bit named `wakeEn` controls an address-wake filter. While `wakeEn` is set, the receiver drops every frame whose ninth bit is 0. The first good ID frame is stored, sets the receive-full flag and pulses the interrupt. That frame also clears `wakeEn` in hardware, so the frames that follow it are received normally. Software writes `wakeEn` back to 1 to go back to skipping frames.

When `wakeEn` is 0, every well-formed frame is received. Reading the data register clears the receive-full flag and both error flags.

The line is oversampled through a clock-enable input `tick`, which pulses at 16 times the bit rate.

Top module: `addrWakeRx`

## Requirements
- R1: A frame is one low start bit, 8 data bits least significant first, one ID bit, and one high stop bit. The line idles high. A start is a falling edge seen on a tick. It is confirmed by a low sample 8 ticks later. Every later bit is sampled 16 ticks after the one before it.
- R2: With `wakeEn` at 0, each frame with a high stop bit is handled as follows:
  - `dataOut` is loaded with its data byte.
  - `idBit` is loaded with its ID bit.
  - `rxFull` is set.
  - `irq` pulses, whatever the value of the ID bit.
- R3: With `wakeEn` at 1, a frame whose ID bit is 0 is discarded:
  - `dataOut` and `idBit` keep their values.
  - `rxFull` stays clear.
  - `irq` does not pulse.
  - `wakeEn` stays 1.
- R4: With `wakeEn` at 1, a frame whose ID bit is 1 is stored and pulses `irq`, exactly as in R2.
- R5: `wakeEn` is cleared by hardware when a frame with its ID bit at 1 and a good stop bit ends while `wakeEn` is 1. A write strobe (`wrWake` with `wrWakeVal`) loads `wakeEn`, and a write in the same cycle overrides the hardware clear.
- R6: A one-cycle `rdStrobe` clears `rxFull`, `ovrErr` and `frmErr`. A set of any of these flags in the same cycle takes priority over the clear.
- R7: If a frame would be accepted while `rxFull` is still 1, the following happens:
  - `dataOut` and `idBit` keep their values.
  - `ovrErr` is set.
  - `irq` does not pulse.
  - The `wakeEn` clear of R5 still applies.
- R8: A low sample at the stop position sets `frmErr`. Such a frame is not stored, does not pulse `irq` and leaves `wakeEn` unchanged.
- R9: After reset, the following values hold:
  - `dataOut` is 0.
  - `rxFull`, `ovrErr`, `frmErr`, `idBit`, `wakeEn` and `irq` are all 0.
- R10: `irq` is high for exactly one clock cycle per accepted frame. `dataOut` changes only in a cycle where `irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxLine | input | 1 | Serial input line, idle high |
| rdStrobe | input | 1 | Data register read, clears the flags |
| wrWake | input | 1 | Write strobe for the wake-filter enable |
| wrWakeVal | input | 1 | Value written to the wake-filter enable |
| dataOut | output | 8 | Received data register |
| idBit | output | 1 | ID bit of the last stored frame |
| rxFull | output | 1 | Receive-full flag |
| ovrErr | output | 1 | Overrun flag |
| frmErr | output | 1 | Framing-error flag |
| wakeEn | output | 1 | Wake-filter enable |
| irq | output | 1 | Receive interrupt, one-cycle pulse |

## Verification
The assertions assume the following about the inputs:
- Frames are separated by far more than one clock cycle, so that two `irq` pulses never touch.
- A software write to `wakeEn` is visible through `wrWake` in the cycle it takes effect.

The stimulus keeps to these assumptions:
- Each frame is driven with whole 32-clock bit times, that is 16 ticks with `tick` high every other cycle.
- At least one idle bit time follows each frame.
- Read and write strobes are issued only while the line is idle, never close to a frame end.

// File: rtl/mpRxPkg.sv
package mpRxPkg;
  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic frameDone;
    logic stopOk;
  } rxStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_t;
endpackage

// File: rtl/mpRxCtrl.sv
module mpRxCtrl
  import mpRxPkg::*;
#(
  parameter int OSR        = 16,
  parameter int FRAME_BITS = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxLine,
  output rxStrobes_t strobes
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  rxState_t      state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bitIdx;
  logic          sync1, sync2, rxPrev;
  logic          atEnd;

  assign atEnd = tick && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1  <= 1'b1;
      sync2  <= 1'b1;
      rxPrev <= 1'b1;
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      sync1 <= rxLine;
      sync2 <= sync1;
      if (tick) rxPrev <= sync2;
      case (state)
        ST_IDLE: begin
          if (tick && rxPrev && !sync2) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt == HALF_CNT) begin
              cnt    <= '0;
              bitIdx <= '0;
              state  <= sync2 ? ST_IDLE : ST_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_BITS: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CNT) begin
              cnt <= '0;
              if (bitIdx == LAST_IDX) state <= ST_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CNT) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.shiftEn   = (state == ST_BITS) && atEnd;
    strobes.bitVal    = sync2;
    strobes.frameDone = (state == ST_STOP) && atEnd;
    strobes.stopOk    = sync2;
  end
endmodule

// File: rtl/mpRxData.sv
module mpRxData
  import mpRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic              rdStrobe,
  input  logic              wrWake,
  input  logic              wrWakeVal,
  output logic [DATA_W-1:0] dataOut,
  output logic              idBit,
  output logic              rxFull,
  output logic              ovrErr,
  output logic              frmErr,
  output logic              wakeEn,
  output logic              irq
);
  localparam int FW = DATA_W + 1;

  logic [FW-1:0] shReg;
  logic          frameId, goodEnd, accept, store;

  assign frameId = shReg[FW-1];
  assign goodEnd = strobes.frameDone && strobes.stopOk;
  assign accept  = goodEnd && (!wakeEn || frameId);
  assign store   = accept && !rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      dataOut <= '0;
      idBit   <= 1'b0;
      rxFull  <= 1'b0;
      ovrErr  <= 1'b0;
      frmErr  <= 1'b0;
      wakeEn  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (strobes.shiftEn) shReg <= {strobes.bitVal, shReg[FW-1:1]};
      if (rdStrobe) begin
        rxFull <= 1'b0;
        ovrErr <= 1'b0;
        frmErr <= 1'b0;
      end
      if (strobes.frameDone && !strobes.stopOk) frmErr <= 1'b1;
      if (accept && rxFull) ovrErr <= 1'b1;
      if (store) begin
        dataOut <= shReg[DATA_W-1:0];
        idBit   <= frameId;
        rxFull  <= 1'b1;
        irq     <= 1'b1;
      end
      if (goodEnd && wakeEn && frameId) wakeEn <= 1'b0;
      if (wrWake) wakeEn <= wrWakeVal;
    end
  end
endmodule

// File: rtl/addrWakeRx.sv
module addrWakeRx
  import mpRxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxLine,
  input  logic              rdStrobe,
  input  logic              wrWake,
  input  logic              wrWakeVal,
  output logic [DATA_W-1:0] dataOut,
  output logic              idBit,
  output logic              rxFull,
  output logic              ovrErr,
  output logic              frmErr,
  output logic              wakeEn,
  output logic              irq
);
  localparam int FRAME_BITS = DATA_W + 1;

  rxStrobes_t strobes;

  mpRxCtrl #(.OSR(OSR), .FRAME_BITS(FRAME_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine), .strobes(strobes)
  );

  mpRxData #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdStrobe(rdStrobe),
    .wrWake(wrWake), .wrWakeVal(wrWakeVal), .dataOut(dataOut), .idBit(idBit),
    .rxFull(rxFull), .ovrErr(ovrErr), .frmErr(frmErr), .wakeEn(wakeEn), .irq(irq)
  );
endmodule

// File: rtl/mpRxChecker.sv
module mpRxChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irq,
  input logic              rxFull,
  input logic              wakeEn,
  input logic              wrWake,
  input logic              idBit,
  input logic              ovrErr,
  input logic [DATA_W-1:0] dataOut
);
  // R2: an interrupt always comes with a full register
  a_r2_irq_full: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rxFull);

  // R3/R4: under the filter, only an ID frame can be stored
  a_r4_filter_id_only: assert property (@(posedge clk) disable iff (!rstN)
    (irq && $past(wakeEn)) |-> idBit);

  // R5: storing under the filter clears it unless software wrote it
  a_r5_wake_clear: assert property (@(posedge clk) disable iff (!rstN)
    (irq && $past(wakeEn) && !$past(wrWake)) |-> !wakeEn);

  // R7: overrun keeps the register contents
  a_r7_ovr_keeps: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrErr) |-> (rxFull && $stable(dataOut) && !irq));

  // R10: one-cycle pulse, data moves only with it
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  a_r10_data_moves_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> $stable(dataOut));
endmodule

bind addrWakeRx mpRxChecker #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .irq(irq), .rxFull(rxFull), .wakeEn(wakeEn),
  .wrWake(wrWake), .idBit(idBit), .ovrErr(ovrErr), .dataOut(dataOut)
);

// File: tb/addrWakeRx_test.sv
module addrWakeRx_test;
  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxLine = 1'b1;
  logic       rdStrobe = 1'b0;
  logic       wrWake = 1'b0;
  logic       wrWakeVal = 1'b0;
  logic [7:0] dataOut;
  logic       idBit, rxFull, ovrErr, frmErr, wakeEn, irq;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;
  logic [8:0] expQ[$];

  addrWakeRx uut (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine), .rdStrobe(rdStrobe),
    .wrWake(wrWake), .wrWakeVal(wrWakeVal), .dataOut(dataOut), .idBit(idBit),
    .rxFull(rxFull), .ovrErr(ovrErr), .frmErr(frmErr), .wakeEn(wakeEn), .irq(irq)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rstN && irq) begin
      irqSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected irq", {idBit, dataOut}, 0);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check({idBit, dataOut} == e, "R2/R4 stored frame", {idBit, dataOut}, e);
      end
    end
  end

  task automatic sendFrame(input logic [7:0] d, input logic id, input logic stopB,
                           input bit expStore);
    logic [10:0] bits;
    if (expStore) expQ.push_back({id, d});
    bits = {stopB, id, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      rxLine = bits[i];
      repeat (BITCLK - 1) @(negedge clk);
    end
    @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
  endtask

  task automatic readData();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeWake(input logic v);
    @(negedge clk); wrWake = 1'b1; wrWakeVal = v;
    @(negedge clk); wrWake = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int irqBefore;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(dataOut == 8'h00, "R9 dataOut", dataOut, 0);
    check({rxFull, ovrErr, frmErr, idBit, wakeEn, irq} == 6'b0, "R9 flags",
          {rxFull, ovrErr, frmErr, idBit, wakeEn, irq}, 0);
    rstN = 1'b1;
    repeat (BITCLK) @(negedge clk);

    // R1/R2 filter off, data frame
    irqBefore = irqSeen;
    sendFrame(8'hA5, 1'b0, 1'b1, 1'b1);
    check(dataOut == 8'hA5, "R1 byte order", dataOut, 8'hA5);
    check(rxFull && !idBit, "R2 full, id 0", {rxFull, idBit}, 2'b10);
    check(irqSeen == irqBefore + 1, "R10 single irq", irqSeen - irqBefore, 1);
    readData();
    check(!rxFull, "R6 read clears full", rxFull, 0);

    // R2 filter off, ID frame too
    sendFrame(8'h81, 1'b1, 1'b1, 1'b1);
    check(idBit && rxFull, "R2 id frame received", {idBit, rxFull}, 2'b11);
    readData();

    // R3 filter on, data frame dropped
    writeWake(1'b1);
    check(wakeEn, "R5 software set", wakeEn, 1);
    irqBefore = irqSeen;
    sendFrame(8'h3C, 1'b0, 1'b1, 1'b0);
    check(dataOut == 8'h81 && idBit, "R3 register kept", {idBit, dataOut}, 9'h181);
    check(!rxFull && wakeEn, "R3 no flag, still filtering", {rxFull, wakeEn}, 2'b01);
    check(irqSeen == irqBefore, "R3 no irq", irqSeen - irqBefore, 0);

    // R4/R5 filter on, ID frame accepted and filter cleared
    sendFrame(8'h12, 1'b1, 1'b1, 1'b1);
    check(dataOut == 8'h12 && idBit && rxFull, "R4 id accepted",
          {rxFull, idBit, dataOut}, 10'h312);
    check(!wakeEn, "R5 hw clear", wakeEn, 0);
    readData();

    // R5 data after wake is received normally
    sendFrame(8'h77, 1'b0, 1'b1, 1'b1);
    check(dataOut == 8'h77 && rxFull, "R5 post-wake data", dataOut, 8'h77);

    // R7 overrun
    irqBefore = irqSeen;
    sendFrame(8'h88, 1'b0, 1'b1, 1'b0);
    check(ovrErr && dataOut == 8'h77, "R7 overrun kept", {ovrErr, dataOut}, 9'h177);
    check(irqSeen == irqBefore, "R7 no irq", irqSeen - irqBefore, 0);
    readData();
    check(!ovrErr && !rxFull, "R6 read clears ovr", {ovrErr, rxFull}, 0);

    // R7 overrun of an ID frame under the filter still clears it
    sendFrame(8'h01, 1'b0, 1'b1, 1'b1);
    writeWake(1'b1);
    sendFrame(8'h42, 1'b1, 1'b1, 1'b0);
    check(ovrErr && !wakeEn && dataOut == 8'h01, "R7 ovr id clears wake",
          {ovrErr, wakeEn, dataOut}, 10'h201);
    readData();

    // R8 framing error
    writeWake(1'b1);
    irqBefore = irqSeen;
    sendFrame(8'h55, 1'b1, 1'b0, 1'b0);
    check(frmErr && !rxFull, "R8 frame error", {frmErr, rxFull}, 2'b10);
    check(wakeEn && dataOut == 8'h01, "R8 nothing stored, wake kept",
          {wakeEn, dataOut}, 9'h101);
    check(irqSeen == irqBefore, "R8 no irq", irqSeen - irqBefore, 0);
    readData();
    check(!frmErr, "R6 read clears frmErr", frmErr, 0);

    // R1 recovery after framing error, and software clear of the filter
    writeWake(1'b0);
    check(!wakeEn, "R5 software clear", wakeEn, 0);
    sendFrame(8'hC3, 1'b0, 1'b1, 1'b1);
    check(dataOut == 8'hC3, "R1 recovery frame", dataOut, 8'hC3);
    check(expQ.size() == 0, "R2 all expected frames seen", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule